// File: doc/BRIEF.md
# Multi-Buffer Channel Register Sequencer

This block owns the programmable registers of one DMA channel (source address, destination address, buffer size, control field and next-descriptor pointer) and rewrites them each time a buffer of a multi-buffer transfer ends. Software writes the values and then pulses the channel enable. The enable copies the values into the live registers and into a set of shadow registers. Whenever the data movers report that a buffer has finished, the sequencer picks a new value for each field. A field can be loaded from a descriptor in memory, continued from the running address where the last buffer stopped, or replayed from its shadow copy. A field can also simply keep its current value.

Five mode bits select the policy for each field: an automatic-mode bit, a replay bit for each address side, and a descriptor-disable bit for each side. When a descriptor is needed, the block reads four words through a simple request/acknowledge port. In automatic mode the block can be told to halt at each buffer end until a resume input releases it. The chain finishes and raises a done flag when a buffer ends with automatic mode off and a next pointer of zero.

Top module: `dma_buf_seq`

## Requirements
- R1: A one-cycle pulse on `ch_en_i` loads all five software inputs into the output registers on the next edge. The same edge clears `done_o` and raises `busy_o`, from any state.
- R2: A buffer end (`buf_done_i` while running) with `mode_auto_i`=0 and `next_o`=0 does the following on the next edge: it raises `done_o`, drops `busy_o`, fetches nothing and leaves every register unchanged. `done_o` stays high until the next enable.
- R3: A descriptor fetch happens unless both descriptor-disable bits are 1. It issues four reads at byte addresses `next_o`+0, +4, +8 and +12, which carry the source address, destination address, control word and next pointer in that order. Each request holds, with a stable address, until `fetch_ack_i` is seen.
- R4: When a descriptor is fetched, the control word carries the size in bits [SW-1:0] and the control field in bits [SW+CW-1:SW]. Control and next pointer are taken from the descriptor. An address side whose descriptor-disable bit is 0 takes the descriptor's address.
- R5: An address side with descriptor-disable 1 and replay 0 takes the running address that was present on `src_run_i`/`dst_run_i` at the buffer end.
- R6: An address side with descriptor-disable 1 and replay 1 takes the value captured at the last enable. This holds on every later boundary as well.
- R7: With `mode_auto_i`=1, the size is replayed from the value captured at enable, even when a descriptor is fetched.
- R8: With both descriptor-disable bits 1, no fetch takes place, size and control are replayed, and `next_o` keeps its value. The new values appear on the edge that ends the buffer, or on the edge that resumes it.
- R9: With `mode_auto_i`=1 and `irq_unmask_i`=1, a buffer end raises `stall_o` and changes no register. On the edge where `resume_i` is sampled high, the update or fetch of R3 to R8 starts.
- R10: `buf_done_i` has no effect while idle, stalled or fetching. The registers and `done_o` stay unchanged.
- R11: At most one of `fetch_req_o`, `stall_o` and `done_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en_i | input | 1 | Channel enable pulse, captures software values |
| sw_saddr_i | input | AW | Software source address |
| sw_daddr_i | input | AW | Software destination address |
| sw_size_i | input | SW | Software buffer size |
| sw_ctrl_i | input | CW | Software control field |
| sw_next_i | input | AW | Software next-descriptor pointer |
| mode_auto_i | input | 1 | Automatic mode |
| mode_src_rep_i | input | 1 | Source replay |
| mode_dst_rep_i | input | 1 | Destination replay |
| mode_src_dis_i | input | 1 | Source descriptor disable |
| mode_dst_dis_i | input | 1 | Destination descriptor disable |
| irq_unmask_i | input | 1 | Buffer-complete interrupt unmasked (stall enable) |
| resume_i | input | 1 | Releases a stalled channel |
| buf_done_i | input | 1 | Buffer finished strobe |
| src_run_i | input | AW | Running source address |
| dst_run_i | input | AW | Running destination address |
| fetch_req_o | output | 1 | Descriptor word read request |
| fetch_addr_o | output | AW | Descriptor word byte address |
| fetch_ack_i | input | 1 | Read response valid |
| fetch_data_i | input | AW | Read response word |
| saddr_o | output | AW | Live source address |
| daddr_o | output | AW | Live destination address |
| size_o | output | SW | Live buffer size |
| ctrl_o | output | CW | Live control field |
| next_o | output | AW | Live next-descriptor pointer |
| busy_o | output | 1 | Channel active |
| stall_o | output | 1 | Channel stalled at buffer end |
| done_o | output | 1 | Transfer complete |

## Verification
The bench builds the block with its default widths: 16-bit addresses and 8-bit size and control fields. In that setting one descriptor word holds exactly size plus control, so every bit of the control word is checked. The bench sweeps all 32 mode codes against both stall settings and uses a different descriptor, running address and software value in each case. This reaches every pairing of fetch, contiguous, replay and stall paths. Dedicated runs add a second boundary, where shadow and contiguous values must differ from the first, and a terminating chain followed by stray buffer ends.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_STALL = 2'd2,
      ST_FETCH = 2'd3
   } seq_state_e;

   localparam int DESC_WORDS = 4;
   localparam int DW_SRC = 0;
   localparam int DW_DST = 1;
   localparam int DW_CTL = 2;
   localparam int DW_NXT = 3;
endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
   import dma_seq_pkg::*;
#(
   parameter int NW = DESC_WORDS,
   localparam int IW = $clog2(NW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ch_en,
   input  logic          buf_done,
   input  logic          resume,
   input  logic          auto_mode,
   input  logic          unmask,
   input  logic          need_fetch,
   input  logic          next_zero,
   input  logic          ack,
   output seq_state_e    state,
   output logic [IW-1:0] idx,
   output logic          apply,
   output logic          use_desc,
   output logic          cap_run,
   output logic          done
);
   localparam logic [IW-1:0] LAST = IW'(NW - 1);

   logic boundary, finish, want_stall, go;

   assign boundary   = (state == ST_RUN) && buf_done && !ch_en;
   assign finish     = !auto_mode && next_zero;
   assign want_stall = auto_mode && unmask;
   assign cap_run    = boundary && !finish;
   assign go         = (boundary && !finish && !want_stall) ||
                       ((state == ST_STALL) && resume && !ch_en);
   assign use_desc   = (state == ST_FETCH);
   assign apply      = (go && !need_fetch) ||
                       ((state == ST_FETCH) && ack && (idx == LAST) && !ch_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
         done  <= 1'b0;
      end else if (ch_en) begin
         state <= ST_RUN;
         idx   <= '0;
         done  <= 1'b0;
      end else begin
         unique case (state)
            ST_RUN: begin
               if (boundary && finish) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else if (boundary && want_stall) begin
                  state <= ST_STALL;
               end else if (go && need_fetch) begin
                  state <= ST_FETCH;
                  idx   <= '0;
               end
            end
            ST_STALL: begin
               if (go) begin
                  state <= need_fetch ? ST_FETCH : ST_RUN;
                  idx   <= '0;
               end
            end
            ST_FETCH: begin
               if (ack) begin
                  if (idx == LAST) state <= ST_RUN;
                  else             idx   <= idx + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dma_seq_desc_buf.sv
module dma_seq_desc_buf #(
   parameter int AW = 16,
   parameter int NW = 4,
   localparam int IW = $clog2(NW)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ack,
   input  logic                 active,
   input  logic [IW-1:0]        idx,
   input  logic [AW-1:0]        data,
   output logic [NW-1:0][AW-1:0] words
);
   for (genvar w = 0; w < NW; w++) begin : g_word
      logic [AW-1:0] q;
      logic          hit;
      assign hit = active && ack && (idx == IW'(w));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '0;
         else if (hit) q <= data;
      end
      assign words[w] = hit ? data : q;
   end
endmodule

// File: rtl/dma_seq_addr_pick.sv
module dma_seq_addr_pick #(
   parameter int AW = 16
) (
   input  logic          desc_off,
   input  logic          replay,
   input  logic [AW-1:0] shadow,
   input  logic [AW-1:0] running,
   input  logic [AW-1:0] from_desc,
   output logic [AW-1:0] pick
);
   always_comb begin
      if (!desc_off)   pick = from_desc;
      else if (replay) pick = shadow;
      else             pick = running;
   end
endmodule

// File: rtl/dma_buf_seq.sv
module dma_buf_seq
   import dma_seq_pkg::*;
#(
   parameter int AW = 16,
   parameter int SW = 8,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ch_en_i,
   input  logic [AW-1:0] sw_saddr_i,
   input  logic [AW-1:0] sw_daddr_i,
   input  logic [SW-1:0] sw_size_i,
   input  logic [CW-1:0] sw_ctrl_i,
   input  logic [AW-1:0] sw_next_i,
   input  logic          mode_auto_i,
   input  logic          mode_src_rep_i,
   input  logic          mode_dst_rep_i,
   input  logic          mode_src_dis_i,
   input  logic          mode_dst_dis_i,
   input  logic          irq_unmask_i,
   input  logic          resume_i,
   input  logic          buf_done_i,
   input  logic [AW-1:0] src_run_i,
   input  logic [AW-1:0] dst_run_i,
   output logic          fetch_req_o,
   output logic [AW-1:0] fetch_addr_o,
   input  logic          fetch_ack_i,
   input  logic [AW-1:0] fetch_data_i,
   output logic [AW-1:0] saddr_o,
   output logic [AW-1:0] daddr_o,
   output logic [SW-1:0] size_o,
   output logic [CW-1:0] ctrl_o,
   output logic [AW-1:0] next_o,
   output logic          busy_o,
   output logic          stall_o,
   output logic          done_o
);
   localparam int IW = $clog2(DESC_WORDS);

   if (SW + CW > AW) begin : g_bad_ctl_width
      $error("size and control fields must fit one descriptor word");
   end
   if (AW < IW + 3) begin : g_bad_addr_width
      $error("address width too small for descriptor offsets");
   end

   seq_state_e                  state;
   logic [IW-1:0]               idx;
   logic                        apply, use_desc, cap_run, need_fetch;
   logic [DESC_WORDS-1:0][AW-1:0] dw;

   logic [AW-1:0] next_q, sh_saddr, sh_daddr, run_s_q, run_d_q;
   logic [SW-1:0] size_q, sh_size;
   logic [CW-1:0] ctrl_q, sh_ctrl;
   logic [1:0][AW-1:0] side_q, side_sh, side_run, side_desc, side_new;
   logic [1:0]         side_off, side_rep;

   assign need_fetch = !(mode_src_dis_i && mode_dst_dis_i);

   dma_seq_ctrl #(.NW(DESC_WORDS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en_i), .buf_done(buf_done_i),
      .resume(resume_i), .auto_mode(mode_auto_i), .unmask(irq_unmask_i),
      .need_fetch(need_fetch), .next_zero(next_q == '0), .ack(fetch_ack_i),
      .state(state), .idx(idx), .apply(apply), .use_desc(use_desc),
      .cap_run(cap_run), .done(done_o)
   );

   dma_seq_desc_buf #(.AW(AW), .NW(DESC_WORDS)) u_desc (
      .clk(clk), .rst_n(rst_n), .ack(fetch_ack_i), .active(use_desc),
      .idx(idx), .data(fetch_data_i), .words(dw)
   );

   assign side_off  = {mode_dst_dis_i, mode_src_dis_i};
   assign side_rep  = {mode_dst_rep_i, mode_src_rep_i};
   assign side_sh   = {sh_daddr, sh_saddr};
   assign side_run  = {cap_run ? dst_run_i : run_d_q, cap_run ? src_run_i : run_s_q};
   assign side_desc = {dw[DW_DST], dw[DW_SRC]};

   for (genvar s = 0; s < 2; s++) begin : g_side
      dma_seq_addr_pick #(.AW(AW)) u_pick (
         .desc_off(side_off[s]), .replay(side_rep[s]), .shadow(side_sh[s]),
         .running(side_run[s]), .from_desc(side_desc[s]), .pick(side_new[s])
      );
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       side_q[s] <= '0;
         else if (ch_en_i) side_q[s] <= (s == 0) ? sw_saddr_i : sw_daddr_i;
         else if (apply)   side_q[s] <= side_new[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q   <= '0;
         ctrl_q   <= '0;
         next_q   <= '0;
         sh_saddr <= '0;
         sh_daddr <= '0;
         sh_size  <= '0;
         sh_ctrl  <= '0;
         run_s_q  <= '0;
         run_d_q  <= '0;
      end else if (ch_en_i) begin
         size_q   <= sw_size_i;
         ctrl_q   <= sw_ctrl_i;
         next_q   <= sw_next_i;
         sh_saddr <= sw_saddr_i;
         sh_daddr <= sw_daddr_i;
         sh_size  <= sw_size_i;
         sh_ctrl  <= sw_ctrl_i;
      end else begin
         if (cap_run) begin
            run_s_q <= src_run_i;
            run_d_q <= dst_run_i;
         end
         if (apply) begin
            size_q <= (mode_auto_i || !use_desc) ? sh_size : dw[DW_CTL][SW-1:0];
            ctrl_q <= use_desc ? dw[DW_CTL][SW +: CW] : sh_ctrl;
            next_q <= use_desc ? dw[DW_NXT] : next_q;
         end
      end
   end

   assign fetch_req_o  = (state == ST_FETCH);
   assign fetch_addr_o = next_q + AW'({idx, 2'b00});
   assign saddr_o      = side_q[0];
   assign daddr_o      = side_q[1];
   assign size_o       = size_q;
   assign ctrl_o       = ctrl_q;
   assign next_o       = next_q;
   assign busy_o       = (state != ST_IDLE);
   assign stall_o      = (state == ST_STALL);
endmodule

// File: rtl/dma_buf_seq_chk.sv
module dma_buf_seq_chk #(
   parameter int AW = 16,
   parameter int SW = 8,
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ch_en_i,
   input logic [AW-1:0] sw_saddr_i,
   input logic          resume_i,
   input logic          fetch_req_o,
   input logic [AW-1:0] fetch_addr_o,
   input logic          fetch_ack_i,
   input logic [AW-1:0] saddr_o,
   input logic [AW-1:0] daddr_o,
   input logic [SW-1:0] size_o,
   input logic [CW-1:0] ctrl_o,
   input logic          busy_o,
   input logic          stall_o,
   input logic          done_o
);
   // R1: enable loads software values and clears completion
   a_r1_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
      ch_en_i |=> (saddr_o == $past(sw_saddr_i)) && !done_o && busy_o);

   // R2: completion is sticky and leaves the channel idle
   a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !ch_en_i |=> done_o && !busy_o);

   // R3: an unanswered request holds with a stable address
   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req_o && !fetch_ack_i && !ch_en_i |=> fetch_req_o && $stable(fetch_addr_o));

   // R9: a stall freezes the registers until resume
   a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o && !resume_i && !ch_en_i |=>
         stall_o && $stable(saddr_o) && $stable(daddr_o) && $stable(size_o) && $stable(ctrl_o));

   // R10: an idle channel keeps its registers
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !ch_en_i |=> $stable(saddr_o) && $stable(daddr_o) && $stable(size_o));

   // R11: fetch, stall and done are mutually exclusive
   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fetch_req_o, stall_o, done_o}));
endmodule

bind dma_buf_seq dma_buf_seq_chk #(.AW(AW), .SW(SW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ch_en_i(ch_en_i), .sw_saddr_i(sw_saddr_i),
   .resume_i(resume_i), .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
   .fetch_ack_i(fetch_ack_i), .saddr_o(saddr_o), .daddr_o(daddr_o),
   .size_o(size_o), .ctrl_o(ctrl_o), .busy_o(busy_o), .stall_o(stall_o),
   .done_o(done_o)
);

// File: tb/sim_dma_buf_seq.sv
module sim_dma_buf_seq;
   localparam int AW = 16;
   localparam int SW = 8;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          ch_en_i = 0, resume_i = 0, buf_done_i = 0, fetch_ack_i = 0;
   logic          m_auto = 0, m_srep = 0, m_drep = 0, m_sdis = 0, m_ddis = 0, unmask = 0;
   logic [AW-1:0] sw_saddr = 0, sw_daddr = 0, sw_next = 0, src_run = 0, dst_run = 0, fdata = 0;
   logic [SW-1:0] sw_size = 0;
   logic [CW-1:0] sw_ctrl = 0;
   logic          fetch_req_o, busy_o, stall_o, done_o;
   logic [AW-1:0] fetch_addr_o, saddr_o, daddr_o, next_o;
   logic [SW-1:0] size_o;
   logic [CW-1:0] ctrl_o;

   dma_buf_seq #(.AW(AW), .SW(SW), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .ch_en_i(ch_en_i),
      .sw_saddr_i(sw_saddr), .sw_daddr_i(sw_daddr), .sw_size_i(sw_size),
      .sw_ctrl_i(sw_ctrl), .sw_next_i(sw_next),
      .mode_auto_i(m_auto), .mode_src_rep_i(m_srep), .mode_dst_rep_i(m_drep),
      .mode_src_dis_i(m_sdis), .mode_dst_dis_i(m_ddis),
      .irq_unmask_i(unmask), .resume_i(resume_i), .buf_done_i(buf_done_i),
      .src_run_i(src_run), .dst_run_i(dst_run),
      .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
      .fetch_ack_i(fetch_ack_i), .fetch_data_i(fdata),
      .saddr_o(saddr_o), .daddr_o(daddr_o), .size_o(size_o), .ctrl_o(ctrl_o),
      .next_o(next_o), .busy_o(busy_o), .stall_o(stall_o), .done_o(done_o)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] dword(input int k, input int i);
      case (k)
         0:       return AW'(16'h3000 + i);
         1:       return AW'(16'h4000 + i);
         2:       return {8'hC3, 8'(8'h20 + i)};
         default: return AW'(16'h0500 + 16'(i) * 16);
      endcase
   endfunction

   task automatic enable(input int i, input logic [AW-1:0] nxt);
      sw_saddr = AW'(16'h1000 + i);
      sw_daddr = AW'(16'h2000 + i);
      sw_size  = SW'(8'h10 + i);
      sw_ctrl  = CW'(8'h5A ^ i);
      sw_next  = nxt;
      ch_en_i  = 1;
      @(negedge clk);
      ch_en_i  = 0;
      chk("R1 saddr", saddr_o, sw_saddr);
      chk("R1 daddr", daddr_o, sw_daddr);
      chk("R1 next", next_o, sw_next);
      chk("R1 busy/done", {busy_o, done_o}, 2'b10);
   endtask

   task automatic run_case(input int i);
      logic fetch;
      logic [AW-1:0] rs, rd, es, ed, nb;
      logic [SW-1:0] esz;
      logic [CW-1:0] ect;
      fetch = !(m_sdis && m_ddis);
      nb = AW'(16'h0800 + 16'(i) * 32);
      enable(i, nb);
      rs = AW'(16'h1100 + 16'(i) * 3);
      rd = AW'(16'h2200 + 16'(i) * 5);
      src_run = rs; dst_run = rd;
      buf_done_i = 1;
      @(negedge clk);
      buf_done_i = 0;
      src_run = 16'hFFFF; dst_run = 16'hEEEE;
      if (m_auto && unmask) begin
         chk("R9 stall raised", stall_o, 1);
         chk("R9 saddr frozen", saddr_o, sw_saddr);
         buf_done_i = 1;
         @(negedge clk);
         buf_done_i = 0;
         chk("R10 done ignored in stall", {stall_o, size_o}, {1'b1, sw_size});
         resume_i = 1;
         @(negedge clk);
         resume_i = 0;
      end
      if (fetch) begin
         for (int k = 0; k < 4; k++) begin
            chk("R3 request", fetch_req_o, 1);
            chk("R3 address", fetch_addr_o, nb + AW'(4 * k));
            if (k == 1) begin
               buf_done_i = 1;
               @(negedge clk);
               buf_done_i = 0;
               chk("R3 held", {fetch_req_o, fetch_addr_o}, {1'b1, nb + AW'(4)});
            end
            fetch_ack_i = 1;
            fdata = dword(k, i);
            @(negedge clk);
            fetch_ack_i = 0;
         end
      end
      es  = m_sdis ? (m_srep ? sw_saddr : rs) : dword(0, i);
      ed  = m_ddis ? (m_drep ? sw_daddr : rd) : dword(1, i);
      esz = (m_auto || !fetch) ? sw_size : SW'(8'h20 + i);
      ect = fetch ? CW'(8'hC3) : sw_ctrl;
      chk("R4/R5/R6 saddr", saddr_o, es);
      chk("R4/R5/R6 daddr", daddr_o, ed);
      chk("R7 size", size_o, esz);
      chk("R4/R8 ctrl", ctrl_o, ect);
      chk("R8 next", next_o, fetch ? dword(3, i) : nb);
      chk("R11 running", {fetch_req_o, stall_o, done_o, busy_o}, 4'b0001);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset state", {busy_o, stall_o, done_o, fetch_req_o}, 0);
      rst_n = 1;
      @(negedge clk);

      // sweep all mode codes with and without stall
      for (int m = 0; m < 32; m++) begin
         for (int u = 0; u < 2; u++) begin
            {m_auto, m_srep, m_drep, m_sdis, m_ddis} = 5'(m);
            unmask = u[0];
            run_case(m * 2 + u);
         end
      end

      // R6/R5: second boundary in automatic replay/contiguous mode
      {m_auto, m_srep, m_drep, m_sdis, m_ddis} = 5'b11011;
      unmask = 0;
      enable(70, 16'h0900);
      for (int b = 0; b < 2; b++) begin
         src_run = AW'(16'h7000 + b); dst_run = AW'(16'h7100 + b);
         buf_done_i = 1;
         @(negedge clk);
         buf_done_i = 0;
         chk("R6 saddr replay again", saddr_o, sw_saddr);
         chk("R5 daddr contiguous again", daddr_o, AW'(16'h7100 + b));
         chk("R8 next kept", next_o, 16'h0900);
      end

      // R2: chain end, then R10 stray buffer ends while idle
      {m_auto, m_srep, m_drep, m_sdis, m_ddis} = 5'b00000;
      enable(80, 16'h0000);
      src_run = 16'h1234; dst_run = 16'h5678;
      buf_done_i = 1;
      @(negedge clk);
      buf_done_i = 0;
      chk("R2 done", {done_o, busy_o, fetch_req_o}, 3'b100);
      chk("R2 saddr kept", saddr_o, sw_saddr);
      chk("R2 daddr kept", daddr_o, sw_daddr);
      repeat (2) begin
         buf_done_i = 1;
         @(negedge clk);
         buf_done_i = 0;
         chk("R10 idle ignore", {done_o, saddr_o}, {1'b1, sw_saddr});
         chk("R10 idle size", size_o, sw_size);
      end
      enable(81, 16'h0000);
      chk("R1 done cleared", done_o, 0);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule